// File: doc/BRIEF.md
# Quadrature Encoder Counter

This block turns the signals of an incremental shaft encoder into position, index and speed figures. It takes two phase inputs and an index input, all already synchronous to the system clock. Each input is compared with its value from the previous cycle, and each detected step moves a 32-bit position counter up or down by one. Rising edges of the index input are counted separately. A velocity counter gathers steps over a fixed measurement window, and its total is captured when the window closes.

The phase inputs can be read in two ways. In quadrature mode they are a 90-degree pair, decoded at either 2X or 4X resolution. In clock/direction mode one input gives the count direction and the other carries the step pulses. The sense of the direction and the polarity of the index are both selectable. Four one-cycle command strobes arm self-clearing actions, and their pending state can be read back.

Top module: `qei_counter`

## Requirements
- R1: In quadrature mode with 4X selected, a change of exactly one phase counts one step. Taking the state as {A,B}, the sequence 00→10→11→01→00 adds one per step and sets `dir` to 1, and the reverse sequence subtracts one per step and sets `dir` to 0.
- R2: In quadrature mode with 2X selected, only a change of A alone counts. A change of B alone leaves the position unchanged.
- R3: In quadrature mode, a cycle where both phases change, or where neither changes, leaves the position unchanged.
- R4: In clock/direction mode, each edge of B (rising or falling) counts one step: up when A is 1, down when A is 0. A change of A alone does not count.
- R5: With `cfg_dir_inv` at 1, both the count direction and the reported `dir` are the complement of the decoded direction.
- R6: The position counter wraps modulo 2^32. One step down from 0 gives 0xFFFFFFFF, and one step up from there gives 0.
- R7: A `cmd_pos_clr` strobe sets `cmd_pending[0]` in the next cycle. One cycle later the position is 0 and the bit is 0 again. The clear wins over a step that arrives in the same cycle.
- R8: A `cmd_pos_clr_on_idx` strobe sets `cmd_pending[1]`. The bit stays set until the next index rising edge. At that edge the position becomes 0 and the bit clears.
- R9: `idx_count` goes up by one on each rising edge of the index input after polarity correction (`idx` XOR `cfg_idx_inv`). Changing `cfg_idx_inv` on its own does not create an edge.
- R10: A `cmd_idx_clr` strobe sets `cmd_pending[3]`. One cycle later `idx_count` is 0 and the bit has cleared. The clear wins over an index edge in that cycle.
- R11: The velocity timer runs for `vel_reload`+1 cycles. When it expires, `vel_capture` takes the number of steps counted in that window, and the count restarts from zero.
- R12: A `cmd_vel_clr` strobe sets `cmd_pending[2]`. One cycle later the velocity count is cleared, the timer is reloaded and the bit clears. A new window then starts.
- R13: After reset, position, index count, captured velocity, `dir` and `cmd_pending` are all 0. In the first cycle after reset, the inputs are only sampled and nothing is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pha | input | 1 | Phase A (or direction in clock/direction mode) |
| phb | input | 1 | Phase B (or step clock in clock/direction mode) |
| idx | input | 1 | Index pulse input |
| cfg_clkdir | input | 1 | 1 selects clock/direction mode, 0 selects quadrature |
| cfg_x4 | input | 1 | 1 selects 4X, 0 selects 2X (quadrature mode only) |
| cfg_dir_inv | input | 1 | Inverts the direction |
| cfg_idx_inv | input | 1 | Inverts the index polarity |
| vel_reload | input | 32 | Velocity timer reload value |
| cmd_pos_clr | input | 1 | Strobe: clear the position |
| cmd_pos_clr_on_idx | input | 1 | Strobe: clear the position at the next index edge |
| cmd_vel_clr | input | 1 | Strobe: clear the velocity count and reload the timer |
| cmd_idx_clr | input | 1 | Strobe: clear the index count |
| dir | output | 1 | Direction of the last counted step |
| position | output | 32 | Position counter |
| idx_count | output | 32 | Index pulse counter |
| vel_capture | output | 32 | Last captured velocity count |
| cmd_pending | output | 4 | Pending command bits {idx clr, vel clr, clr on idx, pos clr} |

## Verification
Phase and index inputs are sampled at a clock edge. Position, `dir` and `idx_count` change at that same edge, so each input is driven on a falling edge and its result is read on the next falling edge. A command strobe shows up in `cmd_pending` one edge after it is given. Its effect on the counter and the clearing of the bit follow one edge after that, except the clear-on-index command, which waits for an index edge. The bench therefore checks the pending bit and the unchanged counter after one falling edge, and the cleared state after the second. For velocity, the bench counts edges from the clear command onwards: the clear acts at the second edge, and the capture lands `vel_reload`+1 edges later, where the bench reads it.

// File: rtl/qei_counter.sv
module qei_counter #(
  parameter int POS_W = 32,
  parameter int IDX_W = 32,
  parameter int VEL_W = 32,
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pha,
  input  logic             phb,
  input  logic             idx,
  input  logic             cfg_clkdir,
  input  logic             cfg_x4,
  input  logic             cfg_dir_inv,
  input  logic             cfg_idx_inv,
  input  logic [TMR_W-1:0] vel_reload,
  input  logic             cmd_pos_clr,
  input  logic             cmd_pos_clr_on_idx,
  input  logic             cmd_vel_clr,
  input  logic             cmd_idx_clr,
  output logic             dir,
  output logic [POS_W-1:0] position,
  output logic [IDX_W-1:0] idx_count,
  output logic [VEL_W-1:0] vel_capture,
  output logic [3:0]       cmd_pending
);

  logic primed, a_q, b_q, idx_q;
  logic pend_pos, pend_arm, pend_vel, pend_idx;
  logic [VEL_W-1:0] vel_cnt;
  logic [TMR_W-1:0] tmr;

  wire a_chg     = pha ^ a_q;
  wire b_chg     = phb ^ b_q;
  wire quad_step = cfg_x4 ? (a_chg ^ b_chg) : (a_chg & ~b_chg);
  wire raw_step  = cfg_clkdir ? b_chg : quad_step;
  wire raw_fwd   = cfg_clkdir ? pha : (pha ^ b_q);
  wire step      = primed & raw_step;
  wire eff_fwd   = raw_fwd ^ cfg_dir_inv;
  wire idx_rise  = primed & (idx ^ cfg_idx_inv) & ~(idx_q ^ cfg_idx_inv);
  wire pos_clr   = pend_pos | (pend_arm & idx_rise);
  wire tmr_done  = (tmr == '0);

  assign cmd_pending = {pend_idx, pend_vel, pend_arm, pend_pos};

  // input history
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      primed <= 1'b0;
      a_q    <= 1'b0;
      b_q    <= 1'b0;
      idx_q  <= 1'b0;
    end else begin
      primed <= 1'b1;
      a_q    <= pha;
      b_q    <= phb;
      idx_q  <= idx;
    end

  // self-clearing commands
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_pos <= 1'b0;
      pend_arm <= 1'b0;
      pend_vel <= 1'b0;
      pend_idx <= 1'b0;
    end else begin
      pend_pos <= cmd_pos_clr;
      pend_arm <= cmd_pos_clr_on_idx | (pend_arm & ~idx_rise);
      pend_vel <= cmd_vel_clr;
      pend_idx <= cmd_idx_clr;
    end

  // position and direction
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      position <= '0;
      dir      <= 1'b0;
    end else begin
      if (step) dir <= eff_fwd;
      if (pos_clr)
        position <= '0;
      else if (step)
        position <= eff_fwd ? position + POS_W'(1) : position - POS_W'(1);
    end

  // index counter
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      idx_count <= '0;
    else if (pend_idx)
      idx_count <= '0;
    else if (idx_rise)
      idx_count <= idx_count + IDX_W'(1);

  // velocity window
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vel_cnt     <= '0;
      vel_capture <= '0;
      tmr         <= '0;
    end else if (pend_vel) begin
      vel_cnt <= '0;
      tmr     <= vel_reload;
    end else if (tmr_done) begin
      vel_capture <= vel_cnt + VEL_W'(step);
      vel_cnt     <= '0;
      tmr         <= vel_reload;
    end else begin
      tmr     <= tmr - TMR_W'(1);
      vel_cnt <= vel_cnt + VEL_W'(step);
    end

  AST_POS_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !pos_clr |=> (position == $past(position) || position == $past(position) + POS_W'(1)
                  || position == $past(position) - POS_W'(1))); // R1
  AST_DOUBLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !cfg_clkdir && a_chg && b_chg && !pos_clr) |=> $stable(position)); // R3
  AST_POS_CLR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_pos |=> position == '0); // R7
  AST_ARM_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_arm && idx_rise && !cmd_pos_clr_on_idx) |=> (position == '0 && !pend_arm)); // R8
  AST_IDX_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rise && !pend_idx) |=> idx_count == $past(idx_count) + IDX_W'(1)); // R9
  AST_IDX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_idx |=> idx_count == '0); // R10
  AST_VEL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_done && !pend_vel) |=> (vel_cnt == '0 && tmr == $past(vel_reload))); // R11
  AST_VEL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vel |=> (vel_cnt == '0 && !pend_vel || cmd_vel_clr)); // R12

endmodule

// File: tb/tb_qei_counter.sv
module tb_qei_counter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pha = 0, phb = 0, idx = 0;
  logic cfg_clkdir = 0, cfg_x4 = 1, cfg_dir_inv = 0, cfg_idx_inv = 0;
  logic [31:0] vel_reload = 32'd9;
  logic cmd_pos_clr = 0, cmd_pos_clr_on_idx = 0, cmd_vel_clr = 0, cmd_idx_clr = 0;
  logic dir;
  logic [31:0] position, idx_count, vel_capture;
  logic [3:0] cmd_pending;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qei_counter dut (.*);

  task automatic tick; @(negedge clk); endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_to(input logic a, input logic b);
    pha = a; phb = b; tick();
  endtask

  task automatic t_reset;
    chk("R13 position", position, 0);
    chk("R13 idx_count", idx_count, 0);
    chk("R13 vel_capture", vel_capture, 0);
    chk("R13 dir", {31'd0, dir}, 0);
    chk("R13 pending", {28'd0, cmd_pending}, 0);
  endtask

  task automatic t_quad4x;
    cfg_x4 = 1;
    step_to(1, 0); chk("R1 fwd1", position, 1); chk("R1 dir fwd", {31'd0, dir}, 1);
    step_to(1, 1); chk("R1 fwd2", position, 2);
    step_to(0, 1); chk("R1 fwd3", position, 3);
    step_to(0, 0); chk("R1 fwd4", position, 4);
    step_to(0, 1); chk("R1 rev1", position, 3); chk("R1 dir rev", {31'd0, dir}, 0);
    step_to(1, 1); chk("R1 rev2", position, 2);
    step_to(1, 0); chk("R1 rev3", position, 1);
    step_to(0, 0); chk("R1 rev4", position, 0);
  endtask

  task automatic t_illegal;
    step_to(1, 1); chk("R3 double change", position, 0);
    step_to(1, 1); chk("R3 no change", position, 0);
    step_to(0, 0); chk("R3 double back", position, 0);
  endtask

  task automatic t_quad2x;
    cfg_x4 = 0;
    step_to(1, 0); chk("R2 A edge", position, 1);
    step_to(1, 1); chk("R2 B edge ignored", position, 1);
    step_to(0, 1); chk("R2 A edge 2", position, 2);
    step_to(0, 0); chk("R2 B edge ignored 2", position, 2);
    cfg_x4 = 1;
  endtask

  task automatic t_wrap;
    step_to(0, 1); chk("R6 down", position, 1);
    step_to(1, 1); chk("R6 down to zero", position, 0);
    step_to(1, 0); chk("R6 wrap below zero", position, 32'hFFFF_FFFF);
    step_to(1, 1); chk("R6 wrap above max", position, 0);
    step_to(0, 1);
    step_to(0, 0); chk("R6 resume", position, 2);
  endtask

  task automatic t_dirinv;
    cfg_dir_inv = 1;
    step_to(1, 0); chk("R5 inverted count", position, 1); chk("R5 inverted dir", {31'd0, dir}, 0);
    step_to(0, 0); chk("R5 inverted back", position, 2); chk("R5 inverted dir2", {31'd0, dir}, 1);
    cfg_dir_inv = 0;
  endtask

  task automatic t_clkdir;
    cfg_clkdir = 1;
    tick(); chk("R4 mode switch no step", position, 2);
    step_to(1, 1); chk("R4 A change no step, B rise up", position, 3);
    step_to(1, 0); chk("R4 B fall up", position, 4);
    step_to(1, 1); chk("R4 B rise up", position, 5);
    step_to(0, 1); chk("R4 A alone ignored", position, 5);
    step_to(0, 0); chk("R4 down", position, 4);
    cfg_clkdir = 0;
  endtask

  task automatic t_posclr;
    cmd_pos_clr = 1; tick(); cmd_pos_clr = 0;
    chk("R7 pending set", {28'd0, cmd_pending}, 4'b0001);
    chk("R7 not yet cleared", position, 4);
    tick();
    chk("R7 cleared", position, 0);
    chk("R7 bit cleared", {28'd0, cmd_pending}, 0);
    step_to(1, 0); chk("R7 count again", position, 1);
    cmd_pos_clr = 1; tick(); cmd_pos_clr = 0;
    step_to(1, 1); chk("R7 clear beats step", position, 0);
    step_to(0, 1);
    step_to(0, 0); chk("R7 after priority", position, 2);
  endtask

  task automatic t_clr_on_idx;
    cmd_pos_clr_on_idx = 1; tick(); cmd_pos_clr_on_idx = 0;
    chk("R8 armed", {28'd0, cmd_pending}, 4'b0010);
    repeat (3) tick();
    chk("R8 still armed", {28'd0, cmd_pending}, 4'b0010);
    chk("R8 waits for index", position, 2);
    idx = 1; tick();
    chk("R8 cleared on index", position, 0);
    chk("R8 bit cleared", {28'd0, cmd_pending}, 0);
    idx = 0; tick();
  endtask

  task automatic t_index;
    cmd_idx_clr = 1; tick(); cmd_idx_clr = 0;
    chk("R10 pending set", {28'd0, cmd_pending}, 4'b1000);
    tick();
    chk("R10 cleared", idx_count, 0);
    chk("R10 bit cleared", {28'd0, cmd_pending}, 0);
    for (int i = 1; i <= 3; i++) begin
      idx = 1; tick(); chk("R9 rising edge", idx_count, i);
      idx = 0; tick(); chk("R9 falling no count", idx_count, i);
    end
    cfg_idx_inv = 1; tick(); chk("R9 polarity flip no edge", idx_count, 3);
    idx = 1; tick(); chk("R9 inverted fall", idx_count, 3);
    idx = 0; tick(); chk("R9 inverted rise", idx_count, 4);
    cfg_idx_inv = 0; tick();
    cmd_idx_clr = 1; tick(); cmd_idx_clr = 0;
    idx = 1; tick(); chk("R10 clear beats edge", idx_count, 0);
    idx = 0; tick();
  endtask

  task automatic t_velocity;
    cmd_vel_clr = 1; tick(); cmd_vel_clr = 0;
    chk("R12 pending set", {28'd0, cmd_pending}, 4'b0100);
    tick();
    chk("R12 bit cleared", {28'd0, cmd_pending}, 0);
    step_to(1, 0); step_to(1, 1); step_to(0, 1); step_to(0, 0);
    repeat (6) tick();
    chk("R11 capture of 4 steps", vel_capture, 4);
    repeat (10) tick();
    chk("R11 idle window", vel_capture, 0);
    vel_reload = 32'd4;
    step_to(1, 0); step_to(1, 1);
    repeat (8) tick();
    chk("R11 window with 2 steps", vel_capture, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick(); tick();
    t_reset();
    t_quad4x();
    t_illegal();
    t_quad2x();
    t_wrap();
    t_dirinv();
    t_clkdir();
    t_posclr();
    t_clr_on_idx();
    t_index();
    t_velocity();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule